// File: doc/BRIEF.md
# Edge-Coded Isolated Channel Link

This block moves up to five logic levels between a system side and a field side without ever carrying a raw level across the divide between them. Each transmitting end watches its input and, whenever the level changes, sends a one-cycle "drive high" or "drive low" strobe pair toward the far end. There, a latch per line is changed only by those strobes. Because a strobe can be lost or damaged in transit, every transmitter also runs a per-line background timer. When a line stays quiet for a full refresh period, the timer resends the present level, so a wrong far-end latch is repaired within a bounded time.

Each line is one-way. The parameter `F2S_LINES` picks how many lines carry data from field to system, and those lines take the top indices. The remaining low-index lines carry data from system to field. Each side has its own enable. A low enable releases that side's outputs (the output-enable bits go low and the data bits are forced low) and freezes the inputs that side feeds. After reset, both sides stay dark for a hold-off of `HOLD_CYC` cycles. Time constants are given as clock-cycle counts. The per-line strobe pairs can be dropped or swapped through two fault-injection vectors, which model a barrier disturbance.

Top module: `edge_link_top`

## Requirements
- R1: Line i carries field-to-system data when i >= NUM_LINES-F2S_LINES, and system-to-field data otherwise. On the side a line does not drive, its data and output-enable bits stay 0.
- R2: An input level present at the clock edge where the transmitter samples it appears on the far-side data output after the next edge, which is two edges in total. A one-cycle pulse is reproduced as a one-cycle pulse.
- R3: On a line with no input change, the transmitter resends its held level every REF_CYC cycles.
- R4: After a dropped (drop_i) or swapped (flip_i) strobe corrupts a receive latch, the output is correct again within 2*REF_CYC cycles once the fault stops.
- R5: When an input change falls on the cycle a refresh is due, the change is sent and the refresh timer of that line restarts from zero.
- R6: For HOLD_CYC edges after reset is released, no strobe is sent and every output-enable bit is 0.
- R7: While a side's enable is 0, all of that side's output-enable and data bits are 0. Its receive latches still follow incoming strobes, so raising the enable shows the current value in the same cycle.
- R8: While a side's enable is 0, changes on the inputs that side feeds are ignored and the held level keeps being refreshed. On re-enable, a changed input is sent as a normal edge.

Parameters: NUM_LINES (5), F2S_LINES (2), REF_CYC (500), HOLD_CYC (3000). drop_i bit i deletes both strobes of line i. flip_i bit i exchanges them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_en_i | input | 1 | System-side enable |
| fld_en_i | input | 1 | Field-side enable |
| sys_in_i | input | NUM_LINES | System-side inputs (used on system-to-field lines) |
| fld_in_i | input | NUM_LINES | Field-side inputs (used on field-to-system lines) |
| drop_i | input | NUM_LINES | Per-line fault: discard strobes in transit |
| flip_i | input | NUM_LINES | Per-line fault: swap high/low strobes |
| sys_out_o | output | NUM_LINES | System-side data outputs |
| sys_oe_o | output | NUM_LINES | System-side output enables (0 = high impedance) |
| fld_out_o | output | NUM_LINES | Field-side data outputs |
| fld_oe_o | output | NUM_LINES | Field-side output enables (0 = high impedance) |

## Verification
The properties assume that reset starts with the hold-off pending. They also assume that the inputs are stable around each rising edge, so a single level is seen per sample. The stimulus changes every input a quarter period after the rising edge and releases reset between edges. Fault vectors are asserted only in windows that the bench model also applies, so the refresh-gap property still holds while latches are corrupted. The inputs that a line does not use are driven with random values, which confirms they have no effect.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } strobe_t;

  // barrier disturbance model: drop wins over swap
  function automatic strobe_t barrier_xfer(strobe_t s, logic drop, logic swap);
    strobe_t r;
    if (drop)      r = '0;
    else if (swap) r = '{hi: s.lo, lo: s.hi};
    else           r = s;
    return r;
  endfunction

endpackage

// File: rtl/edge_link_por.sv
module edge_link_por #(
  parameter int HOLD_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rdy_o
);
  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else if (!rdy_o) begin
      if (cnt_q == LAST) rdy_o <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/edge_link_tx.sv
module edge_link_tx
  import edge_link_pkg::*;
#(
  parameter int REF_CYC = 500
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rdy_i,
  input  logic    en_i,
  input  logic    din_i,
  output strobe_t stb_o
);
  localparam int CW = (REF_CYC < 2) ? 1 : $clog2(REF_CYC);
  localparam logic [CW-1:0] LAST = CW'(REF_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          nxt_lvl;
  logic          chg;

  assign nxt_lvl = en_i ? din_i : lvl_q;  // disabled side holds last level
  assign chg     = nxt_lvl != lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      stb_o <= '0;
    end else if (!rdy_i) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      stb_o <= '0;
    end else begin
      lvl_q <= nxt_lvl;
      if (chg) begin
        // edge beats a due refresh and restarts the timer
        stb_o <= '{hi: nxt_lvl, lo: ~nxt_lvl};
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        stb_o <= '{hi: lvl_q, lo: ~lvl_q};
        cnt_q <= '0;
      end else begin
        stb_o <= '0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_link_rx.sv
module edge_link_rx
  import edge_link_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rdy_i,
  input  logic    en_i,
  input  strobe_t stb_i,
  output logic    out_o,
  output logic    oe_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= 1'b0;
    else if (stb_i.hi)  q_q <= 1'b1;
    else if (stb_i.lo)  q_q <= 1'b0;
  end

  assign oe_o  = rdy_i & en_i;
  assign out_o = oe_o & q_q;
endmodule

// File: rtl/edge_link_top.sv
module edge_link_top
  import edge_link_pkg::*;
#(
  parameter int NUM_LINES = 5,
  parameter int F2S_LINES = 2,
  parameter int REF_CYC   = 500,
  parameter int HOLD_CYC  = 3000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sys_en_i,
  input  logic                 fld_en_i,
  input  logic [NUM_LINES-1:0] sys_in_i,
  input  logic [NUM_LINES-1:0] fld_in_i,
  input  logic [NUM_LINES-1:0] drop_i,
  input  logic [NUM_LINES-1:0] flip_i,
  output logic [NUM_LINES-1:0] sys_out_o,
  output logic [NUM_LINES-1:0] sys_oe_o,
  output logic [NUM_LINES-1:0] fld_out_o,
  output logic [NUM_LINES-1:0] fld_oe_o
);
  // set bits mark field-to-system lines (top indices)
  localparam logic [NUM_LINES-1:0] F2S_MASK = ~({NUM_LINES{1'b1}} >> F2S_LINES);

  logic                 rdy_w;
  logic [NUM_LINES-1:0] tx_din_w, tx_en_w, rx_en_w;
  logic [NUM_LINES-1:0] tx_set_w, tx_clr_w, rx_set_w, rx_clr_w;
  logic [NUM_LINES-1:0] rx_out_w, rx_oe_w;

  assign tx_din_w = (sys_in_i & ~F2S_MASK) | (fld_in_i & F2S_MASK);
  assign tx_en_w  = ({NUM_LINES{sys_en_i}} & ~F2S_MASK) | ({NUM_LINES{fld_en_i}} & F2S_MASK);
  assign rx_en_w  = ({NUM_LINES{fld_en_i}} & ~F2S_MASK) | ({NUM_LINES{sys_en_i}} & F2S_MASK);

  edge_link_por #(.HOLD_CYC(HOLD_CYC)) u_por (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rdy_o (rdy_w)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    strobe_t tx_stb, rx_stb;

    edge_link_tx #(.REF_CYC(REF_CYC)) u_tx (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rdy_i (rdy_w),
      .en_i  (tx_en_w[i]),
      .din_i (tx_din_w[i]),
      .stb_o (tx_stb)
    );

    assign rx_stb = barrier_xfer(tx_stb, drop_i[i], flip_i[i]);

    edge_link_rx u_rx (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rdy_i (rdy_w),
      .en_i  (rx_en_w[i]),
      .stb_i (rx_stb),
      .out_o (rx_out_w[i]),
      .oe_o  (rx_oe_w[i])
    );

    assign tx_set_w[i] = tx_stb.hi;
    assign tx_clr_w[i] = tx_stb.lo;
    assign rx_set_w[i] = rx_stb.hi;
    assign rx_clr_w[i] = rx_stb.lo;
  end

  assign sys_out_o = rx_out_w & F2S_MASK;
  assign sys_oe_o  = rx_oe_w  & F2S_MASK;
  assign fld_out_o = rx_out_w & ~F2S_MASK;
  assign fld_oe_o  = rx_oe_w  & ~F2S_MASK;
endmodule

// File: rtl/edge_link_chk.sv
module edge_link_chk #(
  parameter int NUM_LINES = 5,
  parameter int F2S_LINES = 2,
  parameter int REF_CYC   = 500
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sys_en_i,
  input logic                 fld_en_i,
  input logic [NUM_LINES-1:0] sys_out_o,
  input logic [NUM_LINES-1:0] sys_oe_o,
  input logic [NUM_LINES-1:0] fld_out_o,
  input logic [NUM_LINES-1:0] fld_oe_o,
  input logic                 rdy_i,
  input logic [NUM_LINES-1:0] tx_set_i,
  input logic [NUM_LINES-1:0] tx_clr_i,
  input logic [NUM_LINES-1:0] rx_set_i,
  input logic [NUM_LINES-1:0] rx_clr_i
);
  localparam logic [NUM_LINES-1:0] MASK = ~({NUM_LINES{1'b1}} >> F2S_LINES);
  localparam int GW = $clog2(REF_CYC) + 2;
  localparam logic [GW-1:0] GMAX = GW'(REF_CYC);

  logic [NUM_LINES-1:0] far_out, far_oe;
  assign far_out = (sys_out_o & MASK) | (fld_out_o & ~MASK);
  assign far_oe  = (sys_oe_o  & MASK) | (fld_oe_o  & ~MASK);

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |-> ((tx_set_i | tx_clr_i) == '0)); // R6
  AST_HOLD_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |-> (sys_oe_o == '0 && fld_oe_o == '0)); // R6
  AST_IDLE_SIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sys_oe_o | sys_out_o) & ~MASK) == '0 && ((fld_oe_o | fld_out_o) & MASK) == '0); // R1
  AST_OFF_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sys_out_o & ~sys_oe_o) | (fld_out_o & ~fld_oe_o)) == '0); // R7
  AST_SYS_EN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_en_i |-> sys_oe_o == '0); // R7
  AST_FLD_EN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fld_en_i |-> fld_oe_o == '0); // R7

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             gap_q <= '0;
      else if (!rdy_i || tx_set_i[i] || tx_clr_i[i]) gap_q <= '0;
      else if (gap_q != '1)                    gap_q <= gap_q + 1'b1;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tx_set_i[i] && tx_clr_i[i])); // R2
    AST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_set_i[i] && !rx_clr_i[i]) |=> (!far_oe[i] || far_out[i])); // R2
    AST_CLR_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_clr_i[i] && !rx_set_i[i]) |=> !far_out[i]); // R2
    AST_REFRESH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_q <= GMAX); // R3
  end
endmodule

bind edge_link_top edge_link_chk #(
  .NUM_LINES(NUM_LINES),
  .F2S_LINES(F2S_LINES),
  .REF_CYC  (REF_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sys_en_i (sys_en_i),
  .fld_en_i (fld_en_i),
  .sys_out_o(sys_out_o),
  .sys_oe_o (sys_oe_o),
  .fld_out_o(fld_out_o),
  .fld_oe_o (fld_oe_o),
  .rdy_i    (rdy_w),
  .tx_set_i (tx_set_w),
  .tx_clr_i (tx_clr_w),
  .rx_set_i (rx_set_w),
  .rx_clr_i (rx_clr_w)
);

// File: tb/edge_link_top_test.sv
module edge_link_top_test;
  localparam int CLK_T = 10;
  localparam int NL    = 5;
  localparam int F2S   = 2;
  localparam int REF   = 16;
  localparam int HOLD  = 20;
  localparam int WDOG  = 100000;

  logic clk = 0, rst_n = 0, sys_en = 1, fld_en = 1;
  logic [NL-1:0] sys_in = '0, fld_in = '0, drop = '0, flip = '0;
  logic [NL-1:0] sys_out, sys_oe, fld_out, fld_oe;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;

  edge_link_top #(.NUM_LINES(NL), .F2S_LINES(F2S), .REF_CYC(REF), .HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_en_i(sys_en), .fld_en_i(fld_en),
    .sys_in_i(sys_in), .fld_in_i(fld_in), .drop_i(drop), .flip_i(flip),
    .sys_out_o(sys_out), .sys_oe_o(sys_oe), .fld_out_o(fld_out), .fld_oe_o(fld_oe));

  // behavioural reference model
  bit m_rdy; int m_hc;
  bit m_lvl[NL], m_set[NL], m_clr[NL], m_q[NL];
  int m_cnt[NL];

  function automatic bit is_f2s(int i);
    return i >= NL - F2S;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_hc = 0;
      for (int i = 0; i < NL; i++) begin
        m_lvl[i] = 0; m_set[i] = 0; m_clr[i] = 0; m_q[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        bit rs, rc, t, en, d, nl;
        rs = m_set[i] && !drop[i];
        rc = m_clr[i] && !drop[i];
        if (flip[i]) begin t = rs; rs = rc; rc = t; end
        if (rs) m_q[i] = 1; else if (rc) m_q[i] = 0;
        en = is_f2s(i) ? fld_en : sys_en;
        d  = is_f2s(i) ? fld_in[i] : sys_in[i];
        if (!m_rdy) begin
          m_lvl[i] = 0; m_cnt[i] = 0; m_set[i] = 0; m_clr[i] = 0;
        end else begin
          nl = en ? d : m_lvl[i];
          if (nl != m_lvl[i]) begin
            m_set[i] = nl; m_clr[i] = !nl; m_cnt[i] = 0;
          end else if (m_cnt[i] == REF - 1) begin
            m_set[i] = m_lvl[i]; m_clr[i] = !m_lvl[i]; m_cnt[i] = 0;
          end else begin
            m_set[i] = 0; m_clr[i] = 0; m_cnt[i]++;
          end
          m_lvl[i] = nl;
        end
      end
      if (!m_rdy) begin
        m_hc++;
        if (m_hc == HOLD) m_rdy = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [NL-1:0] eso, ess, efo, efs;
      for (int i = 0; i < NL; i++) begin
        bit oe;
        oe = m_rdy && (is_f2s(i) ? sys_en : fld_en);
        ess[i] = is_f2s(i) && oe;
        efs[i] = !is_f2s(i) && oe;
        eso[i] = ess[i] && m_q[i];
        efo[i] = efs[i] && m_q[i];
      end
      chk(sys_out == eso && fld_out == efo, "R2 data vs model",
          int'({sys_out, fld_out}), int'({eso, efo}));
      chk(sys_oe == ess && fld_oe == efs, "R7 oe vs model",
          int'({sys_oe, fld_oe}), int'({ess, efs}));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #(CLK_T/4); end
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      summary();
    end
  end

  initial begin
    int n;
    // R6: reset and hold-off
    step(3);
    chk(sys_oe == 0 && fld_oe == 0, "R6 reset oe", int'({sys_oe, fld_oe}), 0);
    rst_n = 1;
    sys_in = 5'b00001;             // present during hold-off, must not cross yet
    step(HOLD - 2);
    chk(fld_oe == 0 && fld_out == 0, "R6 still held", int'({fld_oe, fld_out}), 0);
    step(4);
    chk(fld_oe == 5'b00111, "R1 field oe on s2f lines", fld_oe, 5'b00111);
    chk(sys_oe == 5'b11000, "R1 system oe on f2s lines", sys_oe, 5'b11000);
    step(3);
    chk(fld_out[0] == 1, "R6 level crosses after hold-off", fld_out[0], 1);

    // R2 latency: two edges
    sys_in[1] = 1;
    step(1);
    chk(fld_out[1] == 0, "R2 not yet after one edge", fld_out[1], 0);
    step(1);
    chk(fld_out[1] == 1, "R2 after two edges", fld_out[1], 1);

    // R1: field-to-system line
    fld_in[4] = 1;
    sys_in[4] = 1;
    step(2);
    chk(sys_out[4] == 1 && fld_out[4] == 0, "R1 line4 direction",
        int'({sys_out[4], fld_out[4]}), 2);

    // R2: one-cycle pulse
    sys_in[2] = 1; step(1); sys_in[2] = 0;
    step(1);
    chk(fld_out[2] == 1, "R2 pulse high", fld_out[2], 1);
    step(1);
    chk(fld_out[2] == 0, "R2 pulse low", fld_out[2], 0);

    // R5: edge on the cycle a refresh is due
    n = 0;
    while (m_cnt[2] != REF - 1 && n < 4 * REF) begin step(1); n++; end
    sys_in[2] = 1;
    step(2);
    chk(fld_out[2] == 1, "R5 edge wins over refresh", fld_out[2], 1);
    step(REF + 2);
    chk(fld_out[2] == 1, "R5 level kept", fld_out[2], 1);

    // R3: lost edge repaired by the next refresh
    drop[3] = 1; fld_in[3] = 1;
    step(2); drop[3] = 0;
    n = 2;
    while (sys_out[3] != 1 && n < 3 * REF) begin step(1); n++; end
    chk(n <= REF + 2, "R3 refresh repairs line3", n, REF + 2);

    // R4: dropped strobe
    drop[0] = 1; sys_in[0] = 0;
    step(3);
    chk(fld_out[0] == 1, "R4 drop took effect", fld_out[0], 1);
    drop[0] = 0;
    n = 0;
    while (fld_out[0] != 0 && n < 3 * REF) begin step(1); n++; end
    chk(n <= 2 * REF, "R4 recovery after drop", n, 2 * REF);

    // R4: swapped strobes
    flip[1] = 1; sys_in[1] = 0;
    step(REF + 4);
    chk(fld_out[1] == 1, "R4 flip took effect", fld_out[1], 1);
    flip[1] = 0;
    n = 0;
    while (fld_out[1] != 0 && n < 3 * REF) begin step(1); n++; end
    chk(n <= 2 * REF, "R4 recovery after flip", n, 2 * REF);

    // R8: disabled input side
    sys_en = 0; sys_in[0] = 1;
    step(2 * REF + 4);
    chk(fld_out[0] == 0, "R8 input ignored", fld_out[0], 0);
    chk(sys_oe == 0 && sys_out == 0, "R7 system side released", int'({sys_oe, sys_out}), 0);
    sys_en = 1;
    step(2);
    chk(fld_out[0] == 1, "R8 sent on re-enable", fld_out[0], 1);

    // R7: disabled output side keeps tracking
    fld_en = 0; sys_in[2] = 0;
    #1;
    chk(fld_oe == 0 && fld_out == 0, "R7 field side released", int'({fld_oe, fld_out}), 0);
    step(4);
    fld_en = 1;
    #1;
    chk(fld_out[2] == 0 && fld_oe[2] == 1, "R7 current on re-enable",
        int'({fld_out[2], fld_oe[2]}), 1);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      step(1);
      sys_in = NL'($urandom);
      fld_in = NL'($urandom);
      sys_en = ($urandom % 8) != 0;
      fld_en = ($urandom % 8) != 0;
      drop   = (($urandom % 16) == 0) ? NL'($urandom) : '0;
      flip   = (($urandom % 16) == 0) ? NL'($urandom) : '0;
    end
    drop = '0; flip = '0; sys_en = 1; fld_en = 1;
    step(2 * REF + 2);
    chk(fld_out == (sys_in & 5'b00111), "R4 settled field side", fld_out, sys_in & 5'b00111);
    chk(sys_out == (fld_in & 5'b11000), "R4 settled system side", sys_out, fld_in & 5'b11000);
    summary();
  end
endmodule